// File: doc/BRIEF.md
# Broadcast Message Receive Queue with Software Acknowledge

This block sits at the receiving end of a node-to-node broadcast messaging path. Each message that arrives is bound to one of eight acknowledge resources. Its 32-byte entry is written into a circular payload queue at the current tail slot, and a one-cycle interrupt pulse is sent to the local cores. Software services the message from the queue and then releases the resource by a write-one-to-clear store to an acknowledge register.

The sender receives exactly one reply per message. It is a normal reply if software clears the pending bit in time. It is an error reply if the programmable acknowledge timer runs out first. A timed-out resource stays held until software clears it, and that later clear produces no further reply. A new message is held off while all eight resources are held, and also while the queue slot at the tail still belongs to a held message.

Top module: `msg_dest_queue`

## Requirements
- R1: After reset, the status word is zero, `msg_ready` is high, no reply or interrupt is asserted, and the timeout limit reads 64.
- R2: An accepted message takes the lowest-numbered free resource. In the same cycle, `q_we` is high, `q_idx` equals the tail, and `q_data` carries the following fields: payload in bits 95:0, header address bits in 119:96, a one-hot resource vector in 127:120, supplementary bytes in 143:128, and zeros above.
- R3: The tail advances by one per accepted message and wraps from slot 16 back to slot 0.
- R4: In the cycle after acceptance, `irq` pulses on every core when `msg_int_both` was set, and only on core 0 otherwise.
- R5: Writing a word to address 1 that clears the pending bit of a resource that has not timed out produces, in the next cycle, a normal reply on that resource's lane (`rep_valid` bit set, `rep_error` bit clear, and the message's sender on the lane). The resource is then free.
- R6: With timeout limit L, a message not acknowledged produces an error reply exactly L clock edges after its acceptance edge. The timeout bit is then set, and the pending bit stays set.
- R7: Clearing a timed-out resource frees it and produces no reply.
- R8: The status word at address 0 holds the pending bits in bits 15:8 and the timeout bits in bits 7:0, both indexed by resource. A write to address 1 clears only the bits that are set in the written word. Clearing only the timeout bit of a timed-out resource leaves it held, and no later reply follows. Clear bits aimed at free resources cause no reply.
- R9: `msg_ready` is low while all eight resources are held, and also while the tail slot belongs to a held resource.
- R10: If an acknowledge write and the timer expiry hit the same resource on the same edge, only a normal reply is sent.
- R11: The timeout limit is read and written at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Message can be accepted this cycle |
| msg_sender | input | SW | Sender identifier |
| msg_payload | input | 96 | Sender payload |
| msg_hdr_addr | input | 24 | Header address bits carried into the entry |
| msg_supp | input | 16 | Supplementary header bytes |
| msg_int_both | input | 1 | Interrupt all cores on the node |
| q_we | output | 1 | Queue entry write strobe |
| q_idx | output | QW | Queue slot being written |
| q_data | output | 256 | Queue entry contents |
| rep_valid | output | 8 | Reply issued, one bit per resource |
| rep_error | output | 8 | Reply is an error reply, per resource |
| rep_sender | output | 8*SW | Destination of each resource's reply |
| irq | output | NCORE | Arrival interrupt pulse per core |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 acknowledge clear, 2 limit) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
Acknowledge clears and timer expiry are two functions that can land on the same edge for the same resource. The bench provokes this by scheduling the clear exactly L edges after acceptance. It judges the outcome by requiring one normal reply and no error reply, with silence in the following cycle. It also sweeps every resource through allocation and release, walks the tail around the full ring, and fills the ring around a held slot so that the tail itself blocks entry.

// File: rtl/msg_dest_queue.sv
module msg_dest_queue #(
  parameter int SW = 8,
  parameter int QDEPTH = 17,
  parameter int TW = 16,
  parameter int NCORE = 4,
  parameter logic [TW-1:0] LIMIT_RST = 64,
  localparam int NRES = 8,
  localparam int QW = $clog2(QDEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msg_valid,
  output logic                msg_ready,
  input  logic [SW-1:0]       msg_sender,
  input  logic [95:0]         msg_payload,
  input  logic [23:0]         msg_hdr_addr,
  input  logic [15:0]         msg_supp,
  input  logic                msg_int_both,
  output logic                q_we,
  output logic [QW-1:0]       q_idx,
  output logic [255:0]        q_data,
  output logic [NRES-1:0]     rep_valid,
  output logic [NRES-1:0]     rep_error,
  output logic [NRES*SW-1:0]  rep_sender,
  output logic [NCORE-1:0]    irq,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata
);
  logic [NRES-1:0] pend, tmo, replied;
  logic [TW-1:0]   cnt [NRES];
  logic [QW-1:0]   slot_of [NRES];
  logic [SW-1:0]   sender_of [NRES];
  logic [QW-1:0]   tail;
  logic [TW-1:0]   limit;
  logic            tail_busy;
  logic [NRES-1:0] expire;

  wire [NRES-1:0] held  = pend | tmo;
  wire [NRES-1:0] freev = ~held;
  wire [NRES-1:0] alloc = freev & (~freev + {{(NRES-1){1'b0}}, 1'b1});
  wire            acc   = msg_valid & msg_ready;
  wire            wr_ack = reg_we & (reg_addr == 2'd1);
  wire [NRES-1:0] clr_p = wr_ack ? reg_wdata[15:8] : '0;
  wire [NRES-1:0] clr_t = wr_ack ? reg_wdata[7:0]  : '0;
  wire [NRES-1:0] armed = pend & ~replied;
  wire [NRES-1:0] normal = armed & clr_p;

  always_comb begin
    tail_busy = 1'b0;
    for (int r = 0; r < NRES; r++)
      if (held[r] && slot_of[r] == tail) tail_busy = 1'b1;
  end

  always_comb
    for (int r = 0; r < NRES; r++)
      expire[r] = armed[r] & ~clr_p[r] & (cnt[r] == limit - {{(TW-1){1'b0}}, 1'b1});

  assign msg_ready = (|freev) & ~tail_busy;
  assign q_we   = acc;
  assign q_idx  = tail;
  assign q_data = {112'b0, msg_supp, alloc, msg_hdr_addr, msg_payload};

  for (genvar g = 0; g < NRES; g++) begin : g_lane
    assign rep_sender[g*SW +: SW] = sender_of[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; tmo <= '0; replied <= '0;
      rep_valid <= '0; rep_error <= '0;
      for (int r = 0; r < NRES; r++) begin
        cnt[r] <= '0; slot_of[r] <= '0; sender_of[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NRES; r++) begin
        if (acc && alloc[r]) begin
          pend[r] <= 1'b1; tmo[r] <= 1'b0; replied[r] <= 1'b0;
          cnt[r] <= '0; slot_of[r] <= tail; sender_of[r] <= msg_sender;
        end else begin
          pend[r]    <= pend[r] & ~clr_p[r];
          tmo[r]     <= (tmo[r] & ~clr_t[r]) | expire[r];
          replied[r] <= replied[r] | normal[r] | expire[r];
          if (armed[r]) cnt[r] <= cnt[r] + 1'b1;
        end
      end
      rep_valid <= normal | expire;
      rep_error <= expire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail  <= '0;
      limit <= LIMIT_RST;
      irq   <= '0;
    end else begin
      if (acc) tail <= (tail == QW'(QDEPTH-1)) ? '0 : tail + 1'b1;
      if (reg_we && reg_addr == 2'd2) limit <= reg_wdata[TW-1:0];
      irq <= acc ? (msg_int_both ? '1 : {{(NCORE-1){1'b0}}, 1'b1}) : '0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0, 2'd1: reg_rdata = {16'b0, pend, tmo};
      2'd2:       reg_rdata = {{(32-TW){1'b0}}, limit};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msg_dest_queue_chk.sv
module msg_dest_queue_chk #(
  parameter int QDEPTH = 17,
  parameter int QW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [7:0]    pend,
  input logic [7:0]    tmo,
  input logic [QW-1:0] tail,
  input logic [7:0]    rep_valid,
  input logic [7:0]    rep_error,
  input logic          irq_any
);
  a_r9_ready_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> ((pend | tmo) != 8'hFF));
  a_r6_error_sets_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_error & ~tmo) == 8'h00);
  a_r10_error_is_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_error & ~rep_valid) == 8'h00);
  a_r5_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid & $past(rep_valid)) == 8'h00);
  a_r4_irq_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> $past(msg_valid && msg_ready));
  a_r3_tail_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msg_valid && msg_ready) && $past(tail) == QW'(QDEPTH-1)) |-> tail == '0);
endmodule

bind msg_dest_queue msg_dest_queue_chk #(.QDEPTH(QDEPTH), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .pend(pend), .tmo(tmo), .tail(tail), .rep_valid(rep_valid),
  .rep_error(rep_error), .irq_any(|irq)
);

// File: tb/msg_dest_queue_tb.sv
module msg_dest_queue_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, msg_valid, msg_ready, msg_int_both, q_we, reg_we;
  logic [7:0] msg_sender, rep_valid, rep_error;
  logic [95:0] msg_payload;
  logic [23:0] msg_hdr_addr;
  logic [15:0] msg_supp;
  logic [4:0] q_idx;
  logic [255:0] q_data;
  logic [63:0] rep_sender;
  logic [3:0] irq;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  msg_dest_queue u_dut (.*);

  int checks = 0, errors = 0, exp_tail = 0;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic status(output logic [31:0] v);
    reg_addr = 2'd0; #1; v = reg_rdata;
  endtask

  task automatic send(input logic [7:0] s, input logic ib, input int res, input string req);
    logic [95:0] pl;
    logic [23:0] ha;
    logic [15:0] sp;
    pl = {s, 88'h0} ^ {3{32'hA5C3_0F00 + 32'(s)}};
    ha = 24'h10_2000 + 24'(s);
    sp = 16'hBE00 | 16'(s);
    msg_valid = 1'b1; msg_sender = s; msg_payload = pl; msg_hdr_addr = ha;
    msg_supp = sp; msg_int_both = ib;
    #1;
    check({req, " R9 ready"}, 256'(msg_ready), 256'(1));
    check({req, " R2 q_we"}, 256'(q_we), 256'(1));
    check({req, " R3 q_idx"}, 256'(q_idx), 256'(exp_tail));
    check({req, " R2 q_data"}, q_data, {112'b0, sp, 8'(1 << res), ha, pl});
    @(posedge clk); #1;
    msg_valid = 1'b0;
    check({req, " R4 irq"}, 256'(irq), ib ? 256'hF : 256'h1);
    exp_tail = (exp_tail + 1) % 17;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] st;
    rst_n = 1'b0; msg_valid = 1'b0; msg_sender = '0; msg_payload = '0;
    msg_hdr_addr = '0; msg_supp = '0; msg_int_both = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    status(st);
    check("R1 status", 256'(st), 256'(0));
    check("R1 ready", 256'(msg_ready), 256'(1));
    check("R1 replies", 256'({rep_valid, irq}), 256'(0));
    reg_addr = 2'd2; #1;
    check("R1 R11 limit default", 256'(reg_rdata), 256'(64));
    wr(2'd2, 32'd1000);
    reg_addr = 2'd2; #1;
    check("R11 limit write", 256'(reg_rdata), 256'(1000));

    for (int i = 0; i < 8; i++) begin
      send(8'(i + 10), i[0], i, "R2 fill");
      status(st);
      check("R8 pending grows", 256'(st), 256'(((1 << (i + 1)) - 1) << 8));
    end
    msg_valid = 1'b1; #1;
    check("R9 all held", 256'(msg_ready), 256'(0));
    msg_valid = 1'b0;

    wr(2'd1, 32'hC0C0);
    check("R5 dual reply", 256'(rep_valid), 256'(8'hC0));
    check("R5 dual error", 256'(rep_error), 256'(0));
    check("R5 sender 7", 256'(rep_sender[63:56]), 256'(17));
    for (int r = 0; r < 6; r++) begin
      wr(2'd1, 32'((1 << (r + 8)) | (1 << r)));
      check("R5 reply", 256'(rep_valid), 256'(1 << r));
      check("R5 error", 256'(rep_error), 256'(0));
      check("R5 sender", 256'(rep_sender[r*8 +: 8]), 256'(r + 10));
    end
    status(st);
    check("R5 all free", 256'(st), 256'(0));
    wr(2'd1, 32'hFFFF);
    check("R8 clear of free gives no reply", 256'(rep_valid), 256'(0));

    for (int k = 8; k < 17; k++) begin
      send(8'(k), 1'b0, 0, "R3 walk");
      wr(2'd1, 32'h0101);
      check("R5 walk reply", 256'(rep_valid), 256'(1));
    end
    send(8'h20, 1'b1, 0, "R3 wrapped");
    wr(2'd1, 32'h0101);

    send(8'h30, 1'b0, 0, "R9 hold slot");
    for (int k = 0; k < 16; k++) begin
      send(8'h40, 1'b0, 1, "R9 ring");
      wr(2'd1, 32'h0202);
    end
    msg_valid = 1'b1; #1;
    check("R9 tail slot held", 256'(msg_ready), 256'(0));
    tick(1);
    status(st);
    check("R9 blocked no accept", 256'(st), 256'(16'h0100));
    msg_valid = 1'b0;
    wr(2'd1, 32'h0101);
    check("R5 release slot", 256'(rep_valid), 256'(1));
    #1;
    check("R9 ready again", 256'(msg_ready), 256'(1));

    wr(2'd2, 32'd5);
    send(8'h55, 1'b0, 0, "R6 timer");
    tick(4);
    check("R6 not yet", 256'(rep_valid), 256'(0));
    tick(1);
    check("R6 error reply", 256'({rep_valid, rep_error}), 256'(16'h0101));
    check("R6 error sender", 256'(rep_sender[7:0]), 256'(8'h55));
    status(st);
    check("R6 status", 256'(st), 256'(16'h0101));
    wr(2'd1, 32'h0001);
    check("R8 timeout-only clear no reply", 256'(rep_valid), 256'(0));
    status(st);
    check("R8 still held", 256'(st), 256'(16'h0100));
    tick(6);
    check("R8 no second error", 256'(rep_valid), 256'(0));
    wr(2'd1, 32'h0100);
    check("R7 late clear no reply", 256'(rep_valid), 256'(0));
    status(st);
    check("R7 freed", 256'(st), 256'(0));
    send(8'h66, 1'b0, 0, "R7 reuse");
    wr(2'd1, 32'h0101);
    check("R5 prompt ack", 256'({rep_valid, rep_error}), 256'(16'h0100));

    send(8'h77, 1'b1, 0, "R10 race");
    tick(4);
    wr(2'd1, 32'h0101);
    check("R10 normal reply wins", 256'({rep_valid, rep_error}), 256'(16'h0100));
    tick(1);
    check("R10 no trailing reply", 256'(rep_valid), 256'(0));
    status(st);
    check("R10 freed", 256'(st), 256'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule